// File: doc/BRIEF.md
# Bridge Bus-Lock Sequencing Controller

This block keeps track of whether a bridge is locked. The bridge joins one upstream host link to two downstream PCI segments. The block also gives a verdict on every transaction offered to it while it does so.

Three kinds of request reach it:
- request descriptors from the upstream link;
- inbound request descriptors from each downstream segment, each carrying a memory-window hit flag;
- messages from an interrupt controller.

For each request it returns a registered verdict one cycle later. The verdict is one of four: forward, retry, master abort or hold. For upstream traffic the block also returns the level of the PCI lock pin.

A lock is armed when a locked memory read with a nonzero byte mask is accepted from upstream. The lock takes effect once that read's target segment reports target-ready. The lock then belongs to that segment until an unlock special cycle arrives. While the lock is held, the other segment and the interrupt controller are held back from the upstream link and from the locked segment.

The block does not model PCI signalling, data movement, address decode or arbitration. These appear only as flags: target-ready, window hit and the target segment index.

Top module: `bus_lock_ctrl`

## Requirements
- R1: A lock is armed when the upstream port accepts a request of type 0 (memory read) with the lock bit set and at least one byte enable set. While the lock is armed, `up_ready` is low. The lock becomes held, with that request's segment as owner, only when the `seg_trdy` bit of that same segment is sampled high. A `seg_trdy` pulse from the other segment leaves the lock only armed.
- R2: A locked memory read whose byte enables are all zero is forwarded with the lock pin low and never arms or sets a lock.
- R3: An upstream request of type 4 (special) whose code equals `UNLOCK_CODE` releases a held lock. A special cycle carrying any other code leaves the lock in place.
- R4: While a lock is held, a memory request (type 0 or 1) from the owner segment with the window-hit flag low gets verdict 1 (retry). With the flag high it gets verdict 0 (forward).
- R5: An inbound request of type 2 or 3 (I/O) gets verdict 2 (master abort) on either segment, whether or not a lock is held.
- R6: While a lock is held, every upstream memory request aimed at the owner segment is forwarded with `up_lock_pin` high, even if its own lock bit is clear. A memory request aimed at the other segment with its lock bit clear has the pin low.
- R7: While a lock is held, every inbound request from the non-owner segment gets verdict 3 (hold), and so does every interrupt-controller message. When no lock is held, both get verdict 0.
- R8: A locked, nonzero-mask read that arrives while a lock is already held is forwarded with `up_lock_pin` high. It leaves the owner unchanged and does not arm a new lock.
- R9: An unlock special cycle that arrives while no lock is held is forwarded and has no effect on later verdicts.
- R10: Each accepted request produces its verdict and a one-cycle valid pulse on the clock edge that accepts it. Reset (synchronous, active low) clears the lock, the owner and all valid outputs. Verdict encoding: 0 forward, 1 retry, 2 master abort, 3 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request ready (low while a lock is armed) |
| up_type | input | 3 | Upstream request type (0 mem rd, 1 mem wr, 2 io rd, 3 io wr, 4 special) |
| up_lock | input | 1 | Upstream request lock bit |
| up_be | input | BE_W | Upstream byte enables |
| up_seg | input | SEG_W | Target downstream segment |
| up_spc | input | SPC_W | Special-cycle code |
| seg_trdy | input | NSEG | Target-ready indication, one bit per segment |
| up_dec_valid | output | 1 | Upstream verdict valid |
| up_dec | output | 2 | Upstream verdict |
| up_lock_pin | output | 1 | Lock pin drive for the upstream transaction |
| dn_valid | input | NSEG | Inbound request valid, one bit per segment |
| dn_ready | output | NSEG | Inbound request ready, one bit per segment |
| dn_type | input | 3*NSEG | Inbound request types, 3 bits per segment |
| dn_win_hit | input | NSEG | Inbound address falls inside a memory window |
| dn_dec_valid | output | NSEG | Inbound verdict valid, one bit per segment |
| dn_dec | output | 2*NSEG | Inbound verdicts, 2 bits per segment |
| irq_valid | input | 1 | Interrupt-controller message valid |
| irq_ready | output | 1 | Interrupt-controller message ready |
| irq_dec_valid | output | 1 | Interrupt-controller verdict valid |
| irq_dec | output | 2 | Interrupt-controller verdict |

## Verification
The bench builds the block with two segments and a four-bit byte mask. This keeps the all-zero mask, single-lane masks and the owner/non-owner split small enough to cover exhaustively in a few directed scenarios. The bench overrides `UNLOCK_CODE` to 8'h3C. That makes it possible to send a special cycle carrying the default code 8'h01 and confirm that the lock survives it. Locks are taken on each segment in turn, so both owner values are exercised.

// File: rtl/buslock_pkg.sv
// Shared encodings for the bus-lock controller.
// Assumes a 3-bit request type and a 2-bit verdict field at the ports.
package buslock_pkg;
    typedef enum logic [2:0] {
        RQ_MEM_RD  = 3'd0,
        RQ_MEM_WR  = 3'd1,
        RQ_IO_RD   = 3'd2,
        RQ_IO_WR   = 3'd3,
        RQ_SPECIAL = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        DC_FWD    = 2'd0,
        DC_RETRY  = 2'd1,
        DC_MABORT = 2'd2,
        DC_HOLD   = 2'd3
    } verdict_e;
endpackage

// File: rtl/lock_tracker.sv
// Holds the lock state: armed (waiting for target-ready), held, and owner.
// Assumes arm and release requests are never presented together; the top
// stalls upstream traffic while a lock is armed.
module lock_tracker #(
    parameter int NSEG  = 2,
    parameter int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_req,
    input  logic [SEG_W-1:0] arm_seg,
    input  logic             release_req,
    input  logic [NSEG-1:0]  seg_trdy,
    output logic             held,
    output logic             armed,
    output logic [SEG_W-1:0] owner
);
    logic [SEG_W-1:0] arm_seg_q;

    // Advance the lock state on arm, completion and release events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            armed     <= 1'b0;
            owner     <= '0;
            arm_seg_q <= '0;
        end else begin
            if (release_req) begin
                held <= 1'b0;
            end
            if (arm_req) begin
                armed     <= 1'b1;
                arm_seg_q <= arm_seg;
            end else if (armed && seg_trdy[arm_seg_q]) begin
                armed <= 1'b0;
                held  <= 1'b1;
                owner <= arm_seg_q;
            end
        end
    end
endmodule

// File: rtl/up_decider.sv
// Combinational classification of one upstream request against the lock state.
// Produces the verdict, the lock-pin level, and arm/release strobes.
// Assumes the caller qualifies the strobes with the accept handshake.
module up_decider
    import buslock_pkg::*;
#(
    parameter int             BE_W        = 4,
    parameter int             SPC_W       = 8,
    parameter int             SEG_W       = 1,
    parameter logic [SPC_W-1:0] UNLOCK_CODE = 8'h01
) (
    input  logic [2:0]       kind,
    input  logic             lock_bit,
    input  logic [BE_W-1:0]  be,
    input  logic [SEG_W-1:0] seg,
    input  logic [SPC_W-1:0] spc,
    input  logic             held,
    input  logic [SEG_W-1:0] owner,
    output logic [1:0]       verdict,
    output logic             pin,
    output logic             arm,
    output logic             unlock
);
    logic is_mem;
    logic lock_rd;

    // Classify the request and derive the lock-pin drive.
    always_comb begin
        is_mem  = (kind == RQ_MEM_RD) || (kind == RQ_MEM_WR);
        lock_rd = (kind == RQ_MEM_RD) && lock_bit && (|be);
        arm     = lock_rd && !held;
        unlock  = (kind == RQ_SPECIAL) && (spc == UNLOCK_CODE);
        pin     = is_mem && (arm || (held && ((seg == owner) || lock_rd)));
        verdict = DC_FWD;
    end
endmodule

// File: rtl/in_decider.sv
// Combinational verdict for an inbound request from one downstream segment.
// SEG_IDX is the segment this instance serves.
module in_decider
    import buslock_pkg::*;
#(
    parameter int SEG_W   = 1,
    parameter int SEG_IDX = 0
) (
    input  logic [2:0]       kind,
    input  logic             win_hit,
    input  logic             held,
    input  logic [SEG_W-1:0] owner,
    output logic [1:0]       verdict
);
    localparam logic [SEG_W-1:0] MY_SEG = SEG_W'(SEG_IDX);

    // Apply I/O abort first, then the lock rules, then forward.
    always_comb begin
        if (kind == RQ_IO_RD || kind == RQ_IO_WR) begin
            verdict = DC_MABORT;
        end else if (held && owner != MY_SEG) begin
            verdict = DC_HOLD;
        end else if (held && !win_hit &&
                     (kind == RQ_MEM_RD || kind == RQ_MEM_WR)) begin
            verdict = DC_RETRY;
        end else begin
            verdict = DC_FWD;
        end
    end
endmodule

// File: rtl/bus_lock_ctrl.sv
// Top of the bus-lock controller. It accepts upstream, per-segment inbound
// and interrupt-controller requests and registers a verdict for each one.
// Assumes inbound and interrupt ports are always ready. The upstream port
// stalls only while a lock is armed.
module bus_lock_ctrl
    import buslock_pkg::*;
#(
    parameter int               NSEG        = 2,
    parameter int               BE_W        = 4,
    parameter int               SPC_W       = 8,
    parameter logic [SPC_W-1:0] UNLOCK_CODE = 8'h01,
    localparam int              SEG_W       = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [2:0]        up_type,
    input  logic              up_lock,
    input  logic [BE_W-1:0]   up_be,
    input  logic [SEG_W-1:0]  up_seg,
    input  logic [SPC_W-1:0]  up_spc,
    input  logic [NSEG-1:0]   seg_trdy,
    output logic              up_dec_valid,
    output logic [1:0]        up_dec,
    output logic              up_lock_pin,
    input  logic [NSEG-1:0]   dn_valid,
    output logic [NSEG-1:0]   dn_ready,
    input  logic [3*NSEG-1:0] dn_type,
    input  logic [NSEG-1:0]   dn_win_hit,
    output logic [NSEG-1:0]   dn_dec_valid,
    output logic [2*NSEG-1:0] dn_dec,
    input  logic              irq_valid,
    output logic              irq_ready,
    output logic              irq_dec_valid,
    output logic [1:0]        irq_dec
);
    logic             lock_held;
    logic             lock_armed;
    logic [SEG_W-1:0] lock_owner;
    logic             up_accept;
    logic [1:0]       up_verdict;
    logic             up_pin;
    logic             up_arm;
    logic             up_unlock;

    assign up_ready  = !lock_armed;
    assign up_accept = up_valid && up_ready;
    assign irq_ready = 1'b1;

    lock_tracker #(.NSEG(NSEG), .SEG_W(SEG_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_req     (up_accept && up_arm),
        .arm_seg     (up_seg),
        .release_req (up_accept && up_unlock),
        .seg_trdy    (seg_trdy),
        .held        (lock_held),
        .armed       (lock_armed),
        .owner       (lock_owner)
    );

    up_decider #(
        .BE_W(BE_W), .SPC_W(SPC_W), .SEG_W(SEG_W), .UNLOCK_CODE(UNLOCK_CODE)
    ) u_up (
        .kind     (up_type),
        .lock_bit (up_lock),
        .be       (up_be),
        .seg      (up_seg),
        .spc      (up_spc),
        .held     (lock_held),
        .owner    (lock_owner),
        .verdict  (up_verdict),
        .pin      (up_pin),
        .arm      (up_arm),
        .unlock   (up_unlock)
    );

    // Register the upstream verdict and lock-pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_dec_valid <= 1'b0;
            up_dec       <= DC_FWD;
            up_lock_pin  <= 1'b0;
        end else begin
            up_dec_valid <= up_accept;
            if (up_accept) begin
                up_dec      <= up_verdict;
                up_lock_pin <= up_pin;
            end
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [1:0] seg_verdict;

        assign dn_ready[s] = 1'b1;

        in_decider #(.SEG_W(SEG_W), .SEG_IDX(s)) u_in (
            .kind    (dn_type[3*s +: 3]),
            .win_hit (dn_win_hit[s]),
            .held    (lock_held),
            .owner   (lock_owner),
            .verdict (seg_verdict)
        );

        // Register this segment's inbound verdict.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dn_dec_valid[s]  <= 1'b0;
                dn_dec[2*s +: 2] <= DC_FWD;
            end else begin
                dn_dec_valid[s] <= dn_valid[s];
                if (dn_valid[s]) begin
                    dn_dec[2*s +: 2] <= seg_verdict;
                end
            end
        end
    end

    // Register the interrupt-controller verdict: held back while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_dec_valid <= 1'b0;
            irq_dec       <= DC_FWD;
        end else begin
            irq_dec_valid <= irq_valid;
            if (irq_valid) begin
                irq_dec <= lock_held ? DC_HOLD : DC_FWD;
            end
        end
    end
endmodule

// File: rtl/buslock_checker.sv
// Temporal checks on the bus-lock controller, bound to every instance.
module buslock_checker #(
    parameter int               NSEG        = 2,
    parameter int               SPC_W       = 8,
    parameter logic [SPC_W-1:0] UNLOCK_CODE = 8'h01,
    parameter int               SEG_W       = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_ready,
    input logic [2:0]        up_type,
    input logic [SEG_W-1:0]  up_seg,
    input logic [SPC_W-1:0]  up_spc,
    input logic              up_dec_valid,
    input logic              up_lock_pin,
    input logic [NSEG-1:0]   dn_valid,
    input logic [3*NSEG-1:0] dn_type,
    input logic [2*NSEG-1:0] dn_dec,
    input logic              irq_valid,
    input logic [1:0]        irq_dec,
    input logic              lock_held,
    input logic              lock_armed,
    input logic [SEG_W-1:0]  lock_owner
);
    a_r10_verdict_next: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> up_dec_valid);

    a_r1_lock_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_held) |-> $past(lock_armed));

    a_r1_stall_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        lock_armed |-> !up_ready);

    a_r3_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && up_type == 3'd4 && up_spc == UNLOCK_CODE)
        |=> !lock_held);

    a_r6_owner_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && lock_held && up_seg == lock_owner &&
         (up_type == 3'd0 || up_type == 3'd1)) |=> up_lock_pin);

    a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && lock_held) |=> irq_dec == 2'd3);

    a_r8_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_held && $past(lock_held)) |-> $stable(lock_owner));

    for (genvar g = 0; g < NSEG; g++) begin : g_chk
        a_r5_io_abort: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_valid[g] && (dn_type[3*g +: 3] == 3'd2 || dn_type[3*g +: 3] == 3'd3))
            |=> dn_dec[2*g +: 2] == 2'd2);
    end
endmodule

bind bus_lock_ctrl buslock_checker #(
    .NSEG(NSEG), .SPC_W(SPC_W), .UNLOCK_CODE(UNLOCK_CODE), .SEG_W(SEG_W)
) u_chk (.*);

// File: tb/tb_bus_lock_ctrl.sv
`timescale 1ns/100ps
module tb_bus_lock_ctrl;
    localparam int NSEG = 2;
    localparam int BE_W = 4;
    localparam int SPC_W = 8;
    localparam logic [7:0] UNL = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_valid = 1'b0, up_ready, up_lock = 1'b0;
    logic [2:0] up_type = 3'd0;
    logic [BE_W-1:0] up_be = '0;
    logic up_seg = 1'b0;
    logic [SPC_W-1:0] up_spc = '0;
    logic [NSEG-1:0] seg_trdy = '0;
    logic up_dec_valid, up_lock_pin;
    logic [1:0] up_dec;
    logic [NSEG-1:0] dn_valid = '0, dn_ready, dn_win_hit = '0, dn_dec_valid;
    logic [3*NSEG-1:0] dn_type = '0;
    logic [2*NSEG-1:0] dn_dec;
    logic irq_valid = 1'b0, irq_ready, irq_dec_valid;
    logic [1:0] irq_dec;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    bus_lock_ctrl #(.NSEG(NSEG), .BE_W(BE_W), .SPC_W(SPC_W), .UNLOCK_CODE(UNL)) dut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
        .up_type(up_type), .up_lock(up_lock), .up_be(up_be), .up_seg(up_seg),
        .up_spc(up_spc), .seg_trdy(seg_trdy), .up_dec_valid(up_dec_valid),
        .up_dec(up_dec), .up_lock_pin(up_lock_pin), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .dn_type(dn_type), .dn_win_hit(dn_win_hit),
        .dn_dec_valid(dn_dec_valid), .dn_dec(dn_dec), .irq_valid(irq_valid),
        .irq_ready(irq_ready), .irq_dec_valid(irq_dec_valid), .irq_dec(irq_dec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one upstream request, return verdict and pin sampled after the edge.
    task automatic up_send(input logic [2:0] t, input logic lk, input logic [3:0] be,
                           input logic sg, input logic [7:0] sp,
                           output logic [1:0] d, output logic pin);
        @(negedge clk);
        up_type = t; up_lock = lk; up_be = be; up_seg = sg; up_spc = sp; up_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
        check("R10 upstream verdict valid", up_dec_valid, 1);
        d = up_dec; pin = up_lock_pin;
    endtask

    task automatic dn_send(input int s, input logic [2:0] t, input logic hit,
                           output logic [1:0] d);
        @(negedge clk);
        dn_type[3*s +: 3] = t; dn_win_hit[s] = hit; dn_valid[s] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dn_valid[s] = 1'b0;
        check("R10 inbound verdict valid", dn_dec_valid[s], 1);
        d = dn_dec[2*s +: 2];
    endtask

    task automatic irq_send(output logic [1:0] d);
        @(negedge clk);
        irq_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_valid = 1'b0;
        check("R10 irq verdict valid", irq_dec_valid, 1);
        d = irq_dec;
    endtask

    task automatic trdy(input int s);
        @(negedge clk);
        seg_trdy[s] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        seg_trdy[s] = 1'b0;
    endtask

    // Take a lock on segment s through the full arm/complete sequence.
    task automatic take_lock(input int s);
        logic [1:0] d; logic p;
        up_send(3'd0, 1'b1, 4'b0100, s[0], 8'h00, d, p);
        check("R1 arming read pin", p, 1);
        trdy(s);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 reset up valid", up_dec_valid, 0);
        check("R10 reset dn valid", dn_dec_valid, 0);
        check("R10 reset irq valid", irq_dec_valid, 0);
        check("R1 ready after reset", up_ready, 1);
    endtask

    task automatic t_zero_mask;
        logic [1:0] d; logic p;
        up_send(3'd0, 1'b1, 4'b0000, 1'b0, 8'h00, d, p);
        check("R2 zero-mask verdict", d, 0);
        check("R2 zero-mask pin", p, 0);
        check("R2 no arm", up_ready, 1);
        trdy(0);
        dn_send(1, 3'd0, 1'b0, d);
        check("R2 no lock seg1 fwd", d, 0);
        irq_send(d);
        check("R7 irq fwd unlocked", d, 0);
    endtask

    task automatic t_io_unlocked;
        logic [1:0] d;
        dn_send(0, 3'd2, 1'b1, d);
        check("R5 io rd unlocked", d, 2);
        dn_send(1, 3'd3, 1'b0, d);
        check("R5 io wr unlocked", d, 2);
        @(negedge clk);
        check("R10 valid one cycle", dn_dec_valid, 0);
    endtask

    task automatic t_lock_seg0;
        logic [1:0] d; logic p;
        up_send(3'd0, 1'b1, 4'b0011, 1'b0, 8'h00, d, p);
        check("R1 arming read verdict", d, 0);
        check("R1 arming read pin", p, 1);
        check("R1 ready low while armed", up_ready, 0);
        trdy(1);
        check("R1 other seg trdy ignored", up_ready, 0);
        dn_send(1, 3'd0, 1'b1, d);
        check("R1 not held before trdy", d, 0);
        trdy(0);
        check("R1 ready after completion", up_ready, 1);
    endtask

    task automatic t_locked_inbound;
        logic [1:0] d;
        dn_send(0, 3'd0, 1'b0, d);
        check("R4 owner miss retry", d, 1);
        dn_send(0, 3'd1, 1'b1, d);
        check("R4 owner hit fwd", d, 0);
        dn_send(0, 3'd2, 1'b1, d);
        check("R5 io locked owner", d, 2);
        dn_send(1, 3'd0, 1'b1, d);
        check("R7 other seg hold", d, 3);
        dn_send(1, 3'd3, 1'b1, d);
        check("R5 io locked other", d, 2);
        irq_send(d);
        check("R7 irq hold", d, 3);
    endtask

    task automatic t_pin;
        logic [1:0] d; logic p;
        up_send(3'd1, 1'b0, 4'b1111, 1'b0, 8'h00, d, p);
        check("R6 owner write pin", p, 1);
        up_send(3'd1, 1'b0, 4'b1111, 1'b1, 8'h00, d, p);
        check("R6 other seg pin", p, 0);
        up_send(3'd4, 1'b0, 4'b0000, 1'b0, 8'h01, d, p);
        check("R3 other code verdict", d, 0);
        irq_send(d);
        check("R3 other code keeps lock", d, 3);
    endtask

    task automatic t_second_lock;
        logic [1:0] d; logic p;
        up_send(3'd0, 1'b1, 4'b1000, 1'b1, 8'h00, d, p);
        check("R8 second locked read fwd", d, 0);
        check("R8 second locked read pin", p, 1);
        check("R8 no new arm", up_ready, 1);
        trdy(1);
        dn_send(1, 3'd0, 1'b1, d);
        check("R8 owner unchanged", d, 3);
    endtask

    task automatic t_unlock;
        logic [1:0] d; logic p;
        up_send(3'd4, 1'b0, 4'b0000, 1'b0, UNL, d, p);
        check("R3 unlock verdict", d, 0);
        dn_send(1, 3'd0, 1'b1, d);
        check("R3 seg1 fwd after unlock", d, 0);
        irq_send(d);
        check("R3 irq fwd after unlock", d, 0);
        up_send(3'd1, 1'b0, 4'b1111, 1'b0, 8'h00, d, p);
        check("R3 pin low after unlock", p, 0);
    endtask

    task automatic t_unlock_idle;
        logic [1:0] d; logic p;
        up_send(3'd4, 1'b0, 4'b0000, 1'b1, UNL, d, p);
        check("R9 idle unlock fwd", d, 0);
        dn_send(0, 3'd0, 1'b0, d);
        check("R9 no effect seg0", d, 0);
        check("R9 ready", up_ready, 1);
    endtask

    task automatic t_lock_seg1;
        logic [1:0] d; logic p;
        take_lock(1);
        dn_send(0, 3'd1, 1'b1, d);
        check("R7 seg0 hold owner1", d, 3);
        dn_send(1, 3'd0, 1'b0, d);
        check("R4 owner1 miss retry", d, 1);
        up_send(3'd0, 1'b0, 4'b0001, 1'b1, 8'h00, d, p);
        check("R6 owner1 read pin", p, 1);
        up_send(3'd4, 1'b0, 4'b0000, 1'b0, UNL, d, p);
    endtask

    task automatic t_reset_mid_lock;
        logic [1:0] d;
        take_lock(0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 reset clears valid", up_dec_valid, 0);
        rst_n = 1'b1;
        dn_send(1, 3'd0, 1'b1, d);
        check("R10 reset clears lock", d, 0);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_zero_mask();
        t_io_unlocked();
        t_lock_seg0();
        t_locked_inbound();
        t_pin();
        t_second_lock();
        t_unlock();
        t_unlock_idle();
        t_lock_seg1();
        t_reset_mid_lock();
        finish_run();
    end
endmodule